// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of general-purpose I/O lines controlled through a 32-bit register interface. The interface uses separate read and write strobes and byte offsets. Each line works in one of three modes: a general input, a general output, or an interrupt input.

Interrupt inputs can be level- or edge-sensitive, active-high/rising or active-low/falling, and edge lines can also catch both edges. Each line has its own latched status and enable bit. One combined interrupt output is raised whenever any enabled line has a pending status. Every pin input passes through a synchronizer before any logic uses it. A per-line input-enable register can shut a line's input path off entirely.

Software selects the mode of each line with one bit per register. It then enables the line through a write-one-to-set unmask register and acknowledges edge events through a write-one-to-clear register.

Top module: `gpio_irq_bank`

## Requirements
- R1: The configuration registers read back what was last written. Their byte offsets are: mode 0x00, direction 0x04, output data 0x08, polarity 0x20, sense 0x24, filter 0x28, output source 0x40, both-edge 0x4C, input enable 0x50.
- R2: A line drives its pin (pin_oe bit = 1) only when its mode bit at 0x00 is 0 and its direction bit at 0x04 is 1. pin_out always carries the output data register 0x08.
- R3: Reading 0x0C returns the synchronized pin level ANDed with the input enable bits. This holds even for lines configured as outputs.
- R4: On a line with mode bit 1 and sense bit 1 (edge), a polarity bit of 0 latches a status bit (read at 0x10) on a rising pin edge. A polarity bit of 1 latches it on a falling edge. The edge of the opposite direction does not set it, and the status stays latched after the pin returns. A line with mode bit 0 always reads status 0.
- R5: On an edge line with both-edge bit 1 (0x4C), rising and falling pin edges both set the status bit.
- R6: On a line with mode bit 1 and sense bit 0 (level), the status bit follows the active level: high when the polarity bit is 0, low when it is 1. Clear writes leave this status unchanged.
- R7: Writing 1 to a bit of 0x14 clears that edge line's latched status. Writing 0 leaves it unchanged.
- R8: Reading 0x18 returns the enable bits. A write to 0x18 clears the enable bits written as 0 and keeps those written as 1. A write to 0x1C sets the enable bits written as 1.
- R9: irq is high exactly when some line has both its status bit and its enable bit set.
- R10: A line whose input-enable bit is 0 reads 0 at 0x0C and never becomes active for interrupt detection.
- R11: When an edge event and a clear write to the same line fall in the same cycle, the status bit stays set.
- R12: After reset, every register reads 0, no pin is driven and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; rdata is valid the cycle after |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pin_in | input | NLINES | Pin levels, asynchronous |
| pin_out | output | NLINES | Pin output values |
| pin_oe | output | NLINES | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: 32 lines, a 32-bit data bus and a two-stage synchronizer. With these values the top line (bit 31) can be exercised in both-edge mode, and full 32-bit patterns can be checked on the input data register. Because the synchronizer depth is fixed at two, the bench can time a pin edge so that it lands in exactly the cycle of a clear write, which makes the collision case of R11 observable.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_MODE   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_OUT    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_IN     = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CLR    = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_ENA    = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_ENSET  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_POL    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_SENSE  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_FILT   = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_OSRC   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_BOTH   = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_INEN   = 8'h50;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic [W-1:0] q_r;
    logic [W-1:0] q_n;
    if (s == 0) begin : g_first
      assign q_n = d;
    end else begin : g_next
      assign q_n = g_st[s-1].q_r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_n;
    end
  end

  assign q = g_st[STAGES-1].q_r;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NLINES-1:0] in_data,
  input  logic [NLINES-1:0] status,
  output logic [NLINES-1:0] mode_irq,
  output logic [NLINES-1:0] dir_out,
  output logic [NLINES-1:0] out_val,
  output logic [NLINES-1:0] pol,
  output logic [NLINES-1:0] sense_edge,
  output logic [NLINES-1:0] both_edge,
  output logic [NLINES-1:0] in_en,
  output logic [NLINES-1:0] en_mask,
  output logic [NLINES-1:0] clr_pulse
);
  logic [NLINES-1:0] wbits;
  logic [NLINES-1:0] filt_q, osrc_q;
  logic [NLINES-1:0] mode_n, dir_n, out_n, pol_n, sense_n, both_n, inen_n;
  logic [NLINES-1:0] ena_n, filt_n, osrc_n;
  logic [DATA_W-1:0] rd_n;

  assign wbits = wdata[NLINES-1:0];

  // next-state for writable registers and the clear strobe
  always_comb begin
    mode_n    = mode_irq;
    dir_n     = dir_out;
    out_n     = out_val;
    pol_n     = pol;
    sense_n   = sense_edge;
    both_n    = both_edge;
    inen_n    = in_en;
    ena_n     = en_mask;
    filt_n    = filt_q;
    osrc_n    = osrc_q;
    clr_pulse = '0;
    if (wr_en) begin
      case (addr)
        OFF_MODE:  mode_n    = wbits;
        OFF_DIR:   dir_n     = wbits;
        OFF_OUT:   out_n     = wbits;
        OFF_POL:   pol_n     = wbits;
        OFF_SENSE: sense_n   = wbits;
        OFF_BOTH:  both_n    = wbits;
        OFF_INEN:  inen_n    = wbits;
        OFF_FILT:  filt_n    = wbits;
        OFF_OSRC:  osrc_n    = wbits;
        OFF_CLR:   clr_pulse = wbits;
        OFF_ENA:   ena_n     = en_mask & wbits;
        OFF_ENSET: ena_n     = en_mask | wbits;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_irq   <= '0;
      dir_out    <= '0;
      out_val    <= '0;
      pol        <= '0;
      sense_edge <= '0;
      both_edge  <= '0;
      in_en      <= '0;
      en_mask    <= '0;
      filt_q     <= '0;
      osrc_q     <= '0;
    end else if (wr_en) begin
      mode_irq   <= mode_n;
      dir_out    <= dir_n;
      out_val    <= out_n;
      pol        <= pol_n;
      sense_edge <= sense_n;
      both_edge  <= both_n;
      in_en      <= inen_n;
      en_mask    <= ena_n;
      filt_q     <= filt_n;
      osrc_q     <= osrc_n;
    end
  end

  // read mux
  always_comb begin
    rd_n = '0;
    case (addr)
      OFF_MODE:  rd_n = DATA_W'(mode_irq);
      OFF_DIR:   rd_n = DATA_W'(dir_out);
      OFF_OUT:   rd_n = DATA_W'(out_val);
      OFF_IN:    rd_n = DATA_W'(in_data);
      OFF_STAT:  rd_n = DATA_W'(status);
      OFF_ENA:   rd_n = DATA_W'(en_mask);
      OFF_POL:   rd_n = DATA_W'(pol);
      OFF_SENSE: rd_n = DATA_W'(sense_edge);
      OFF_FILT:  rd_n = DATA_W'(filt_q);
      OFF_OSRC:  rd_n = DATA_W'(osrc_q);
      OFF_BOTH:  rd_n = DATA_W'(both_edge);
      OFF_INEN:  rd_n = DATA_W'(in_en);
      default:   rd_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_n;
  end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] sync_q,
  input  logic [NLINES-1:0] in_en,
  input  logic [NLINES-1:0] mode_irq,
  input  logic [NLINES-1:0] pol,
  input  logic [NLINES-1:0] sense_edge,
  input  logic [NLINES-1:0] both_edge,
  input  logic [NLINES-1:0] clr_pulse,
  output logic [NLINES-1:0] in_data,
  output logic [NLINES-1:0] status
);
  logic [NLINES-1:0] act, act_prev, evt, stat_n;

  assign in_data = sync_q & in_en;
  assign act     = in_en & (sync_q ^ pol);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign evt[i] = both_edge[i] ? (act[i] ^ act_prev[i])
                                 : (act[i] & ~act_prev[i]);
    // edge event outranks a clear in the same cycle
    assign stat_n[i] = !mode_irq[i]   ? 1'b0 :
                       !sense_edge[i] ? act[i] :
                       ((status[i] & ~clr_pulse[i]) | evt[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev <= '0;
      status   <= '0;
    end else begin
      act_prev <= act;
      status   <= stat_n;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NLINES      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq
);
  logic              rst_meta, rst_sync_n;
  logic [NLINES-1:0] sync_q, in_data, status;
  logic [NLINES-1:0] mode_irq, dir_out, out_val, pol, sense_edge, both_edge;
  logic [NLINES-1:0] in_en, en_mask, clr_pulse;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pin_in), .q(sync_q)
  );

  gpio_regs #(.NLINES(NLINES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .in_data(in_data), .status(status),
    .mode_irq(mode_irq), .dir_out(dir_out), .out_val(out_val), .pol(pol),
    .sense_edge(sense_edge), .both_edge(both_edge), .in_en(in_en),
    .en_mask(en_mask), .clr_pulse(clr_pulse)
  );

  gpio_detect #(.NLINES(NLINES)) u_det (
    .clk(clk), .rst_n(rst_sync_n), .sync_q(sync_q), .in_en(in_en),
    .mode_irq(mode_irq), .pol(pol), .sense_edge(sense_edge),
    .both_edge(both_edge), .clr_pulse(clr_pulse),
    .in_data(in_data), .status(status)
  );

  assign pin_out = out_val;
  assign pin_oe  = dir_out & ~mode_irq;
  assign irq     = |(status & en_mask);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [NLINES-1:0] pin_oe,
  input logic              irq,
  input logic [NLINES-1:0] mode_irq,
  input logic [NLINES-1:0] en_mask,
  input logic [NLINES-1:0] status,
  input logic [NLINES-1:0] in_en,
  input logic [NLINES-1:0] in_data
);
  // R2: an interrupt-mode line never drives its pin
  a_r2_irq_line_undriven: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_oe & mode_irq) == '0);

  // R9: nothing enabled means no interrupt
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_mask == '0) |-> !irq);

  // R4: a general I/O line holds no status one cycle on
  a_r4_gpio_no_status: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((status & ~$past(mode_irq)) == '0));

  // R8: write to the enable register clears the zero bits
  a_r8_mask_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == OFF_ENA) |=> ((en_mask & ~$past(wdata[NLINES-1:0])) == '0));

  // R8: write to the set register sets the one bits
  a_r8_unmask_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == OFF_ENSET) |=>
      ((en_mask & $past(wdata[NLINES-1:0])) == $past(wdata[NLINES-1:0])));

  // R10: a disabled input reads as zero
  a_r10_input_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_data & ~in_en) == '0);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NLINES(NLINES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .pin_oe(pin_oe), .irq(irq), .mode_irq(mode_irq),
  .en_mask(en_mask), .status(status), .in_en(in_en), .in_data(in_data)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [N-1:0] pins, pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pins), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic cleanup();
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h20, 0); wr(8'h24, 0);
    wr(8'h4C, 0); wr(8'h18, 0);
    pins = '0;
    settle();
    wr(8'h14, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    foreach (v[i]) ;
    rd(8'h00, v); check("R12 mode", v, 0);
    rd(8'h04, v); check("R12 dir", v, 0);
    rd(8'h08, v); check("R12 out", v, 0);
    rd(8'h10, v); check("R12 status", v, 0);
    rd(8'h18, v); check("R12 enable", v, 0);
    rd(8'h50, v); check("R12 inen", v, 0);
    check("R12 pin_oe", pin_oe, 0);
    check("R12 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h20, 32'hA5A5_0F0F); rd(8'h20, v); check("R1 polarity", v, 32'hA5A5_0F0F);
    wr(8'h24, 32'h1234_8765); rd(8'h24, v); check("R1 sense", v, 32'h1234_8765);
    wr(8'h4C, 32'hC3C3_3C3C); rd(8'h4C, v); check("R1 both", v, 32'hC3C3_3C3C);
    wr(8'h28, 32'hDEAD_BEEF); rd(8'h28, v); check("R1 filter", v, 32'hDEAD_BEEF);
    wr(8'h40, 32'h0BAD_F00D); rd(8'h40, v); check("R1 outsrc", v, 32'h0BAD_F00D);
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, v); check("R1 inen", v, 32'hFFFF_FFFF);
    cleanup();
  endtask

  task automatic t_output();
    logic [31:0] v;
    wr(8'h08, 32'h0000_00F0);
    wr(8'h04, 32'h0000_00FF);
    check("R2 pin_oe", pin_oe, 32'h0000_00FF);
    check("R2 pin_out", pin_out, 32'h0000_00F0);
    rd(8'h08, v); check("R1 out readback", v, 32'h0000_00F0);
    pins = 32'h1234_5678;
    settle();
    rd(8'h0C, v); check("R3 input incl outputs", v, 32'h1234_5678);
    wr(8'h00, 32'h1);
    check("R2 irq line undriven", pin_oe, 32'h0000_00FE);
    cleanup();
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(8'h24, 32'h1); wr(8'h00, 32'h1); wr(8'h14, 32'h1); wr(8'h1C, 32'h1);
    check("R9 idle irq", {31'b0, irq}, 0);
    pins[0] = 1'b1; settle();
    rd(8'h10, v); check("R4 rising sets", v, 32'h1);
    check("R9 irq on", {31'b0, irq}, 1);
    pins[0] = 1'b0; settle();
    rd(8'h10, v); check("R4 latched", v, 32'h1);
    wr(8'h14, 32'h0);
    rd(8'h10, v); check("R7 zero no effect", v, 32'h1);
    wr(8'h14, 32'h1); @(negedge clk);
    rd(8'h10, v); check("R7 clear", v, 32'h0);
    check("R9 irq off", {31'b0, irq}, 0);
    cleanup();
  endtask

  task automatic t_fall();
    logic [31:0] v;
    pins[1] = 1'b1; settle();
    wr(8'h20, 32'h2); wr(8'h24, 32'h2); wr(8'h00, 32'h2);
    wr(8'h14, 32'h2); wr(8'h1C, 32'h2);
    @(negedge clk);
    rd(8'h10, v); check("R4 falling idle", v, 32'h0);
    pins[1] = 1'b0; settle();
    rd(8'h10, v); check("R4 falling sets", v, 32'h2);
    wr(8'h14, 32'h2);
    pins[1] = 1'b1; settle();
    rd(8'h10, v); check("R4 rising ignored", v, 32'h0);
    cleanup();
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(8'h4C, 32'h8000_0000); wr(8'h24, 32'h8000_0000); wr(8'h00, 32'h8000_0000);
    wr(8'h14, 32'h8000_0000);
    pins[31] = 1'b1; settle();
    rd(8'h10, v); check("R5 both rising", v, 32'h8000_0000);
    wr(8'h14, 32'h8000_0000);
    pins[31] = 1'b0; settle();
    rd(8'h10, v); check("R5 both falling", v, 32'h8000_0000);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(8'h00, 32'h8); wr(8'h1C, 32'h8);
    pins[3] = 1'b1; settle();
    rd(8'h10, v); check("R6 level high", v, 32'h8);
    check("R9 level irq", {31'b0, irq}, 1);
    wr(8'h14, 32'h8); @(negedge clk);
    rd(8'h10, v); check("R6 clear ignored", v, 32'h8);
    pins[3] = 1'b0; settle();
    rd(8'h10, v); check("R6 level drops", v, 32'h0);
    check("R9 level irq off", {31'b0, irq}, 0);
    wr(8'h20, 32'h8); settle();
    rd(8'h10, v); check("R6 active low", v, 32'h8);
    cleanup();
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h00, 32'h8); pins[3] = 1'b1;
    wr(8'h1C, 32'h9); settle();
    rd(8'h18, v); check("R8 set", v, 32'h9);
    check("R9 irq enabled", {31'b0, irq}, 1);
    wr(8'h18, 32'hFFFF_FFF7);
    rd(8'h18, v); check("R8 clear zero bits", v, 32'h1);
    rd(8'h10, v); check("R9 status kept", v, 32'h8);
    check("R9 masked irq", {31'b0, irq}, 0);
    wr(8'h1C, 32'h8);
    rd(8'h18, v); check("R8 reset bit", v, 32'h9);
    check("R9 irq back", {31'b0, irq}, 1);
    cleanup();
  endtask

  task automatic t_inen();
    logic [31:0] v;
    wr(8'h50, 32'h0000_FFFF);
    pins = 32'hFFFF_0000;
    wr(8'h00, 32'h0010_0000); wr(8'h1C, 32'h0010_0000);
    settle();
    rd(8'h0C, v); check("R10 input gated", v, 32'h0);
    rd(8'h10, v); check("R10 detect gated", v, 32'h0);
    check("R10 irq gated", {31'b0, irq}, 0);
    wr(8'h50, 32'hFFFF_FFFF); settle();
    rd(8'h10, v); check("R10 detect restored", v, 32'h0010_0000);
    cleanup();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(8'h24, 32'h1); wr(8'h00, 32'h1); wr(8'h14, 32'h1);
    pins[0] = 1'b1; settle();
    pins[0] = 1'b0; settle();
    rd(8'h10, v); check("R11 pre set", v, 32'h1);
    pins[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(8'h14, 32'h1);
    rd(8'h10, v); check("R11 edge beats clear", v, 32'h1);
    wr(8'h14, 32'h1); @(negedge clk);
    rd(8'h10, v); check("R7 clear after collide", v, 32'h0);
    cleanup();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_output();
    wr(8'h50, 32'hFFFF_FFFF);
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_mask();
    t_inen();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all-reqs actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule